// File: doc/BRIEF.md
# Tamper Supervisor with Lockable Recovery

This block supervises a secure always-on domain. Ten tamper sources (voltage, clock, temperature, secure-controller alarm, external boot, two external pins, wire-mesh, monotonic-counter overflow) arrive as single-cycle pulses. A tamper source can also come from the block's own seconds counter when it wraps. Every source latches a sticky detect flag. A source whose enable bit is set also raises the security-violation flag. That flag puts the supervisor into its failure condition, and the seconds counter freezes.

There are two resets. A battery power-on reset clears everything and leaves the non-valid flag set. A system reset keeps the counter, the flags, the enables and the hard locks. It clears the soft lock and the interrupt enable. If the supervisor is in failure, the system reset also raises non-valid, unless the failure hard lock forbids it. Recovery from failure is possible only while non-valid is set. The steps are: write the enables to zero, write ones to the detect flags, write one to the violation flag, and finally write one to the non-valid flag.

Software reaches the block through a plain single-cycle register write strobe and a combinational read port. No data stream crosses the block, so there is no valid/ready handshake. A write is accepted in the cycle its strobe is high.

Top module: `tamper_supervisor`

Register words on `wr_addr` and `rd_addr`:

| Address | Register | Contents |
|---|---|---|
| 0 | seconds counter | the count value |
| 1 | control | bit 3 count enable; bit 16 failure hard lock; bit 29 configuration soft lock; bit 30 configuration hard lock |
| 2 | status | see R2, R8, R9 and R10 |
| 3 | configuration | enable bits 0..9 |
| 4 | interrupt enable | bit 0 |

## Requirements
- R1: A battery power-on reset makes the status read 0x00000002 (non-valid only). It also makes the control, configuration, interrupt-enable and counter registers read zero, and `sv_irq` low.
- R2: A pulse on `tamper_ev[i]`, for i in 0..7, sets status bit 16+i whether or not configuration bit i is set. A flag stays set until a one is written to it. A pulse whose configuration bit is clear does not set status bit 0.
- R3: A pulse on any `tamper_ev[i]` whose configuration bit i is set makes status bit 0 (violation) read one after the next clock edge. `sv_irq` equals status bit 0 AND interrupt-enable bit 0.
- R4: The counter adds one on each cycle with `tick` high, but only while control bit 3 is set and status bits 0 and 1 are both clear. A counter write is accepted whenever status bit 0 is clear.
- R5: A write to the configuration register is ignored while control bit 29 or control bit 30 is set. Writing one to a lock bit sets it, and writing zero to it has no effect.
- R6: A system reset clears control bit 29 and keeps control bit 30. Only a battery power-on reset clears bit 30.
- R7: A system reset clears the interrupt enable. When status bit 0 is set and control bit 16 is clear, the system reset also sets status bit 1. When control bit 16 is set, status bit 1 keeps its value.
- R8: Writing one to status bit 0 clears it only while status bit 1 is set. Writing one to status bit 1 clears it only while status bit 0 is clear. A new enabled event in the same cycle wins over the clear.
- R9: When the counter holds all ones and counts, it wraps to zero and sets status bit 2. If configuration bit 8 is set, the wrap also sets status bit 0.
- R10: A pulse on `tamper_ev[8]` sets status bit 2, and a pulse on `tamper_ev[9]` sets status bit 3. Each of them sets status bit 0 when configuration bit 8 or 9, respectively, is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | always-on domain clock |
| bat_por_n | input | 1 | battery power-on reset, active low, asynchronous |
| sys_rst_n | input | 1 | system reset, active low, synchronous |
| tick | input | 1 | one-second count pulse |
| tamper_ev | input | 10 | single-cycle tamper detections |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | 3 | register word written |
| wr_data | input | 32 | write data |
| rd_addr | input | 3 | register word read |
| rd_data | output | 32 | read data, combinational |
| sv_irq | output | 1 | security-violation interrupt |

## Verification
A lost violation shows up one edge after an enabled pulse: status bit 0 and `sv_irq` read low. A counter that fails to freeze drifts within a few ticks of entering failure or non-valid. A broken lock shows on the next configuration readback after a blocked write. A system reset that handles non-valid wrongly is visible in the status word right after the reset. A recovery gate that is too permissive shows as the violation flag clearing without non-valid set.

// File: rtl/tsup_pkg.sv
package tsup_pkg;
  localparam int DW  = 32;
  localparam int NEV = 10;
  localparam int NDET = 8;

  localparam logic [2:0] A_TIME = 3'd0;
  localparam logic [2:0] A_CTRL = 3'd1;
  localparam logic [2:0] A_STAT = 3'd2;
  localparam logic [2:0] A_CFG  = 3'd3;
  localparam logic [2:0] A_IEN  = 3'd4;

  localparam int C_TEN  = 3;
  localparam int C_FHL  = 16;
  localparam int C_SOFT = 29;
  localparam int C_HARD = 30;

  localparam int S_SV   = 0;
  localparam int S_NV   = 1;
  localparam int S_TOV  = 2;
  localparam int S_MOV  = 3;
  localparam int S_DET0 = 16;

  localparam int E_TOV = 8;
  localparam int E_MOV = 9;
endpackage

// File: rtl/tsup_lockcfg.sv
module tsup_lockcfg
  import tsup_pkg::*;
(
  input  logic           clk,
  input  logic           bat_por_n,
  input  logic           sys_rst_n,
  input  logic           ctrl_wr,
  input  logic           cfg_wr,
  input  logic           ten_d,
  input  logic           fhl_d,
  input  logic           soft_d,
  input  logic           hard_d,
  input  logic [NEV-1:0] en_d,
  output logic           ten,
  output logic           fail_hl,
  output logic           soft_lk,
  output logic           hard_lk,
  output logic [NEV-1:0] ev_en
);
  logic cfg_open;
  assign cfg_open = !soft_lk && !hard_lk;

  always_ff @(posedge clk or negedge bat_por_n) begin
    if (!bat_por_n) begin
      ten     <= 1'b0;
      fail_hl <= 1'b0;
      soft_lk <= 1'b0;
      hard_lk <= 1'b0;
      ev_en   <= '0;
    end else begin
      if (ctrl_wr) begin
        ten     <= ten_d;
        fail_hl <= fail_hl | fhl_d;
        soft_lk <= soft_lk | soft_d;
        hard_lk <= hard_lk | hard_d;
      end
      if (!sys_rst_n) soft_lk <= 1'b0;
      if (cfg_wr && cfg_open) ev_en <= en_d;
    end
  end

  p_cfg_locked_r5: assert property (@(posedge clk) disable iff (!bat_por_n)
    (soft_lk || hard_lk) |=> $stable(ev_en));
  p_hard_keep_r6: assert property (@(posedge clk) disable iff (!bat_por_n)
    hard_lk |=> hard_lk);
  p_soft_drop_r6: assert property (@(posedge clk) disable iff (!bat_por_n)
    !sys_rst_n |=> !soft_lk);
endmodule

// File: rtl/tsup_status.sv
module tsup_status
  import tsup_pkg::*;
(
  input  logic            clk,
  input  logic            bat_por_n,
  input  logic            sys_rst_n,
  input  logic [NEV-1:0]  tamper_ev,
  input  logic [NEV-1:0]  ev_en,
  input  logic            tov_wrap,
  input  logic            fail_hl,
  input  logic            stat_wr,
  input  logic [NDET-1:0] det_clr,
  input  logic            tov_clr,
  input  logic            mov_clr,
  input  logic            nv_clr,
  input  logic            sv_clr,
  input  logic            ien_wr,
  input  logic            ien_d,
  output logic [NDET-1:0] det,
  output logic            tov_f,
  output logic            mov_f,
  output logic            nv,
  output logic            sv,
  output logic            sv_ie
);
  logic [NEV-1:0] ev_all;
  logic           hit;

  always_comb begin
    ev_all        = tamper_ev;
    ev_all[E_TOV] = tamper_ev[E_TOV] | tov_wrap;
  end
  assign hit = |(ev_all & ev_en);

  always_ff @(posedge clk or negedge bat_por_n) begin
    if (!bat_por_n) begin
      det   <= '0;
      tov_f <= 1'b0;
      mov_f <= 1'b0;
      nv    <= 1'b1;
      sv    <= 1'b0;
      sv_ie <= 1'b0;
    end else begin
      det   <= (det & ~(stat_wr ? det_clr : '0)) | ev_all[NDET-1:0];
      tov_f <= (tov_f & !(stat_wr && tov_clr)) | ev_all[E_TOV];
      mov_f <= (mov_f & !(stat_wr && mov_clr)) | ev_all[E_MOV];
      if (hit)                           sv <= 1'b1;
      else if (stat_wr && sv_clr && nv)  sv <= 1'b0;
      if (!sys_rst_n && (sv || hit) && !fail_hl) nv <= 1'b1;
      else if (stat_wr && nv_clr && !sv)          nv <= 1'b0;
      if (!sys_rst_n)  sv_ie <= 1'b0;
      else if (ien_wr) sv_ie <= ien_d;
    end
  end

  p_sv_set_r3: assert property (@(posedge clk) disable iff (!bat_por_n)
    hit |=> sv);
  p_sv_gate_r8: assert property (@(posedge clk) disable iff (!bat_por_n)
    $fell(sv) |-> $past(nv));
  p_nv_gate_r8: assert property (@(posedge clk) disable iff (!bat_por_n)
    $fell(nv) |-> !$past(sv));
  p_det_sticky_r2: assert property (@(posedge clk) disable iff (!bat_por_n)
    ((|det) && !stat_wr) |=> ((det & $past(det)) == $past(det)));
endmodule

// File: rtl/tsup_timer.sv
module tsup_timer #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          bat_por_n,
  input  logic          ten,
  input  logic          sv,
  input  logic          nv,
  input  logic          tick,
  input  logic          wr,
  input  logic [TW-1:0] wdata,
  output logic [TW-1:0] cnt,
  output logic          wrap
);
  logic load, run;
  assign load = wr && !sv;
  assign run  = ten && !sv && !nv && tick;
  assign wrap = run && !load && (&cnt);

  always_ff @(posedge clk or negedge bat_por_n) begin
    if (!bat_por_n)  cnt <= '0;
    else if (load)   cnt <= wdata;
    else if (run)    cnt <= cnt + 1'b1;
  end

  p_hold_r4: assert property (@(posedge clk) disable iff (!bat_por_n)
    ((sv || nv) && !wr) |=> $stable(cnt));
  p_wrap_r9: assert property (@(posedge clk) disable iff (!bat_por_n)
    wrap |=> (cnt == '0));
endmodule

// File: rtl/tamper_supervisor.sv
module tamper_supervisor
  import tsup_pkg::*;
#(
  parameter int TW = 32
) (
  input  logic           clk,
  input  logic           bat_por_n,
  input  logic           sys_rst_n,
  input  logic           tick,
  input  logic [NEV-1:0] tamper_ev,
  input  logic           wr_en,
  input  logic [2:0]     wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic [2:0]     rd_addr,
  output logic [DW-1:0]  rd_data,
  output logic           sv_irq
);
  logic           wr_time, wr_ctrl, wr_stat, wr_cfg, wr_ien;
  logic           ten, fail_hl, soft_lk, hard_lk;
  logic [NEV-1:0] ev_en;
  logic [NDET-1:0] det;
  logic           tov_f, mov_f, nv, sv, sv_ie, wrap;
  logic [TW-1:0]  cnt;

  assign wr_time = wr_en && (wr_addr == A_TIME);
  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
  assign wr_stat = wr_en && (wr_addr == A_STAT);
  assign wr_cfg  = wr_en && (wr_addr == A_CFG);
  assign wr_ien  = wr_en && (wr_addr == A_IEN);

  tsup_lockcfg u_lock (
    .clk(clk), .bat_por_n(bat_por_n), .sys_rst_n(sys_rst_n),
    .ctrl_wr(wr_ctrl), .cfg_wr(wr_cfg),
    .ten_d(wr_data[C_TEN]), .fhl_d(wr_data[C_FHL]),
    .soft_d(wr_data[C_SOFT]), .hard_d(wr_data[C_HARD]),
    .en_d(wr_data[NEV-1:0]),
    .ten(ten), .fail_hl(fail_hl), .soft_lk(soft_lk), .hard_lk(hard_lk),
    .ev_en(ev_en)
  );

  tsup_status u_stat (
    .clk(clk), .bat_por_n(bat_por_n), .sys_rst_n(sys_rst_n),
    .tamper_ev(tamper_ev), .ev_en(ev_en), .tov_wrap(wrap), .fail_hl(fail_hl),
    .stat_wr(wr_stat), .det_clr(wr_data[S_DET0 +: NDET]),
    .tov_clr(wr_data[S_TOV]), .mov_clr(wr_data[S_MOV]),
    .nv_clr(wr_data[S_NV]), .sv_clr(wr_data[S_SV]),
    .ien_wr(wr_ien), .ien_d(wr_data[0]),
    .det(det), .tov_f(tov_f), .mov_f(mov_f), .nv(nv), .sv(sv), .sv_ie(sv_ie)
  );

  tsup_timer #(.TW(TW)) u_tmr (
    .clk(clk), .bat_por_n(bat_por_n), .ten(ten), .sv(sv), .nv(nv),
    .tick(tick), .wr(wr_time), .wdata(wr_data[TW-1:0]),
    .cnt(cnt), .wrap(wrap)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_TIME: rd_data[TW-1:0] = cnt;
      A_CTRL: begin
        rd_data[C_TEN]  = ten;
        rd_data[C_FHL]  = fail_hl;
        rd_data[C_SOFT] = soft_lk;
        rd_data[C_HARD] = hard_lk;
      end
      A_STAT: begin
        rd_data[S_DET0 +: NDET] = det;
        rd_data[S_MOV] = mov_f;
        rd_data[S_TOV] = tov_f;
        rd_data[S_NV]  = nv;
        rd_data[S_SV]  = sv;
      end
      A_CFG:  rd_data[NEV-1:0] = ev_en;
      A_IEN:  rd_data[0] = sv_ie;
      default: rd_data = '0;
    endcase
  end

  assign sv_irq = sv && sv_ie;

  p_irq_needs_sv_r3: assert property (@(posedge clk) disable iff (!bat_por_n)
    sv_irq |-> (rd_addr != A_STAT || rd_data[S_SV]));
endmodule

// File: tb/tamper_supervisor_tb_top.sv
module tamper_supervisor_tb_top;
  logic        clk = 1'b0;
  logic        bat_por_n = 1'b0;
  logic        sys_rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [9:0]  tamper_ev = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        sv_irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tamper_supervisor dut_i (
    .clk(clk), .bat_por_n(bat_por_n), .sys_rst_n(sys_rst_n), .tick(tick),
    .tamper_ev(tamper_ev), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sv_irq(sv_irq)
  );

  function automatic logic [31:0] exp_stat(input logic [9:0] m, input logic [9:0] en);
    logic [31:0] s = '0;
    s[23:16] = m[7:0];
    s[2] = m[8];
    s[3] = m[9];
    s[0] = |(m & en);
    return s;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    rd_addr = a;
    #1 v = rd_data;
  endtask

  task automatic chk_reg(input string req, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [9:0] m);
    @(negedge clk);
    tamper_ev = m;
    @(negedge clk);
    tamper_ev = '0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic sysrst();
    @(negedge clk);
    sys_rst_n = 1'b0;
    @(negedge clk);
    sys_rst_n = 1'b1;
  endtask

  task automatic batpor();
    @(negedge clk);
    bat_por_n = 1'b0;
    #3;
    @(negedge clk);
    bat_por_n = 1'b1;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (2) @(negedge clk);
    sys_rst_n = 1'b1;
    bat_por_n = 1'b1;
    // R1: battery reset state
    chk_reg("R1 status", 3'd2, 32'h2);
    chk_reg("R1 ctrl", 3'd1, 32'h0);
    chk_reg("R1 cfg", 3'd3, 32'h0);
    chk_reg("R1 time", 3'd0, 32'h0);
    chk("R1 irq", {31'b0, sv_irq}, 32'h0);

    // R4: count frozen while non-valid, write accepted
    wr(3'd1, 32'h8);
    wr(3'd0, 32'd100);
    ticks(4);
    chk_reg("R4 frozen nv", 3'd0, 32'd100);
    // R8: clear non-valid, then count
    wr(3'd2, 32'h2);
    chk_reg("R8 nv clear", 3'd2, 32'h0);
    ticks(5);
    chk_reg("R4 counts", 3'd0, 32'd105);

    // R2: disabled event sets only its flag
    pulse(10'h001);
    chk_reg("R2 disabled ev", 3'd2, 32'h0001_0000);

    // R3: enabled event raises violation and irq
    wr(3'd3, 32'h002);
    wr(3'd4, 32'h1);
    pulse(10'h002);
    chk_reg("R3 violation", 3'd2, 32'h0003_0001);
    chk("R3 irq", {31'b0, sv_irq}, 32'h1);
    ticks(3);
    chk_reg("R4 frozen sv", 3'd0, 32'd105);
    wr(3'd0, 32'd7);
    chk_reg("R4 write blocked in failure", 3'd0, 32'd105);

    // R8: violation clear refused without non-valid
    wr(3'd2, 32'h1);
    chk_reg("R8 sv clear refused", 3'd2, 32'h0003_0001);

    // R7: system reset raises non-valid, drops irq enable
    sysrst();
    chk_reg("R7 nv set", 3'd2, 32'h0003_0003);
    chk("R7 irq cleared", {31'b0, sv_irq}, 32'h0);

    // R8: recovery order; nv clear refused while sv set
    wr(3'd2, 32'h2);
    chk_reg("R8 nv clear refused", 3'd2, 32'h0003_0003);
    wr(3'd3, 32'h0);
    wr(3'd2, 32'h0003_0000);
    chk_reg("R2 w1c flags", 3'd2, 32'h3);
    wr(3'd2, 32'h1);
    chk_reg("R8 sv clear", 3'd2, 32'h2);
    wr(3'd2, 32'h2);
    chk_reg("R8 recovered", 3'd2, 32'h0);

    // R5/R6: soft lock
    wr(3'd1, 32'h2000_0008);
    wr(3'd1, 32'h0000_0008);
    chk_reg("R5 soft lock sticky", 3'd1, 32'h2000_0008);
    wr(3'd3, 32'h3FF);
    chk_reg("R5 cfg blocked soft", 3'd3, 32'h0);
    sysrst();
    chk_reg("R6 soft cleared", 3'd1, 32'h0000_0008);
    wr(3'd3, 32'h0F0);
    chk_reg("R5 cfg open", 3'd3, 32'h0F0);

    // R5/R6: hard lock
    wr(3'd1, 32'h4000_0008);
    wr(3'd3, 32'h00F);
    chk_reg("R5 cfg blocked hard", 3'd3, 32'h0F0);
    sysrst();
    chk_reg("R6 hard kept", 3'd1, 32'h4000_0008);
    batpor();
    chk_reg("R6 hard cleared by battery", 3'd1, 32'h0);

    // R7: failure hard lock keeps non-valid clear
    wr(3'd2, 32'h2);
    wr(3'd1, 32'h0001_0000);
    wr(3'd3, 32'h001);
    pulse(10'h001);
    chk_reg("R7 failure", 3'd2, 32'h0001_0001);
    sysrst();
    chk_reg("R7 fail hard lock", 3'd2, 32'h0001_0001);
    wr(3'd2, 32'h1);
    chk_reg("R8 stuck in failure", 3'd2, 32'h0001_0001);

    // R9: counter wrap
    batpor();
    wr(3'd2, 32'h2);
    wr(3'd3, 32'h100);
    wr(3'd1, 32'h8);
    wr(3'd0, 32'hFFFF_FFFF);
    ticks(1);
    chk_reg("R9 wrap value", 3'd0, 32'h0);
    chk_reg("R9 wrap flags", 3'd2, 32'h5);
    ticks(3);
    chk_reg("R9 frozen after wrap", 3'd0, 32'h0);

    // R9: wrap with enable clear sets only the flag
    batpor();
    wr(3'd2, 32'h2);
    wr(3'd1, 32'h8);
    wr(3'd0, 32'hFFFF_FFFE);
    ticks(3);
    chk_reg("R9 wrap no enable value", 3'd0, 32'h1);
    chk_reg("R9 wrap no enable flags", 3'd2, 32'h4);

    // R10: monotonic overflow input
    batpor();
    wr(3'd2, 32'h2);
    wr(3'd3, 32'h200);
    pulse(10'h200);
    chk_reg("R10 mono overflow", 3'd2, 32'h9);

    // R2/R3/R10: random masks against random enables
    for (int i = 0; i < 24; i++) begin
      logic [9:0] en, m;
      en = 10'($urandom);
      m  = 10'($urandom);
      batpor();
      wr(3'd2, 32'h2);
      wr(3'd3, {22'b0, en});
      pulse(m);
      chk_reg("R2 R3 random status", 3'd2, exp_stat(m, en));
    end

    // R8: enabled event beats a same-cycle violation clear
    batpor();
    wr(3'd3, 32'h004);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd2; wr_data = 32'h1; tamper_ev = 10'h004;
    @(negedge clk);
    wr_en = 1'b0; tamper_ev = '0;
    chk_reg("R8 set wins", 3'd2, 32'h0004_0003);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule